// File: doc/BRIEF.md
# Timeslot Zero Data and Alarm Extractor

This block sits beside an E1 receiver that has already found frame alignment. While the timeslot-zero strobe is high, it shifts in the eight bits of timeslot zero, first bit first. At the last bit it decides what the word is for.

- **Non-sync words:** the six user bits go to a parallel register, and bit 3 feeds a remote-alarm persistence filter.
- **Bit 1 of the word:** this is one of the two international bits. It goes to one of two output flops. Which flop, and whether it is taken at all, depends on whether the link runs CRC-4 multiframing.
- **CRC-4 mode:** two frame markers from outside the block say which non-sync frames are multiframe frames 13 and 15.

Frame alignment itself and CRC-4 checking are done elsewhere. This block only trusts the in-alignment flag that the receiver supplies. While that flag is low, it captures nothing and holds its remote alarm low.

Top module: `ts0_extract`

## Requirements
- R1: After reset, `userBits`, `intlSync`, `intlNonSync` and `remoteAlarm` are all 0.
- R2: A word is the eight consecutive strobe-high cycles, carrying bits 1 to 8 in that order. For a non-sync word received in alignment, bits 3..8 are loaded into `userBits[0]..userBits[5]` at the clock edge of bit 8. Bit 3 lands in `userBits[0]`.
- R3: `userBits` keeps its value until the next captured non-sync word. A sync word leaves it unchanged.
- R4: When `inAlign` is low during bit 8, the word changes none of `userBits`, `intlSync` or `intlNonSync`.
- R5: With `crcMode` = 0, bit 1 of each aligned sync word is loaded into `intlSync`.
- R6: With `crcMode` = 0, bit 1 of each aligned non-sync word is loaded into `intlNonSync`.
- R7: With `crcMode` = 1, the international bits come only from aligned non-sync words. Bit 1 goes to `intlSync` when `mark13` is high during bit 8, and to `intlNonSync` when `mark15` is high during bit 8. A non-sync word with neither marker changes neither output. A sync word changes neither output, whatever the markers are.
- R8: `remoteAlarm` rises at the bit-8 edge of the second consecutive aligned non-sync word whose bit 3 is 1.
- R9: An aligned non-sync word with bit 3 = 0 clears `remoteAlarm` at its bit-8 edge, and restarts the persistence count.
- R10: `remoteAlarm` clears on the first clock edge at which `inAlign` is low, and the persistence count restarts. After that, two more qualifying words are needed to raise the alarm again.
- R11: A strobe burst shorter than eight cycles captures nothing. The bit counter restarts whenever the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serialIn | input | 1 | Received serial data |
| tsZeroStrobe | input | 1 | High for the eight bits of timeslot zero |
| syncFrame | input | 1 | High while the current frame carries the alignment word |
| inAlign | input | 1 | Receiver is in frame alignment |
| crcMode | input | 1 | 1 selects CRC-4 multiframe source for the international bits |
| mark13 | input | 1 | Multiframe frame-13 marker, sampled in bit 8 |
| mark15 | input | 1 | Multiframe frame-15 marker, sampled in bit 8 |
| userBits | output | 6 | Bits 3..8 of the last captured non-sync word |
| intlSync | output | 1 | International bit for the sync-side output |
| intlNonSync | output | 1 | International bit for the non-sync-side output |
| remoteAlarm | output | 1 | Persistence-checked remote alarm |

## Verification
A bit counter that slips by one cycle shows up at the ports on the very first word. The captured bits arrive rotated, or a load is missed, one cycle after bit 8. A persistence count that is not cleared when alignment drops shows up later: the alarm rises after only one qualifying word once alignment returns, which is one frame too early. The CRC-4 source selection is exercised with each marker on its own, with neither marker, and with a marker high during a sync word. A wrong decode therefore leaves a stale or wrongly overwritten international bit that is visible right after that word.

// File: rtl/ts0_pkg.sv
package ts0_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadUser;
    logic loadIntlSync;
    logic loadIntlNon;
    logic alarmClear;
  } ts0Strobes_t;
endpackage

// File: rtl/ts0_ctrl.sv
module ts0_ctrl
  import ts0_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tsZeroStrobe,
  input  logic        syncFrame,
  input  logic        inAlign,
  input  logic        crcMode,
  input  logic        mark13,
  input  logic        mark15,
  output ts0Strobes_t strobes
);
  localparam int IDX_W = $clog2(WORD_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BITS - 1);

  logic [IDX_W-1:0] bitIdx;
  logic wordDone, takeSync, takeNon;

  // Position inside timeslot zero; restarts whenever the strobe drops (R11)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitIdx <= '0;
    else if (!tsZeroStrobe) bitIdx <= '0;
    else if (bitIdx == LAST_IDX) bitIdx <= '0;
    else bitIdx <= bitIdx + 1'b1;
  end

  always_comb begin
    wordDone = tsZeroStrobe && (bitIdx == LAST_IDX);
    takeSync = wordDone && inAlign && syncFrame;
    takeNon  = wordDone && inAlign && !syncFrame;
    strobes.shiftEn      = tsZeroStrobe;
    strobes.loadUser     = takeNon;
    strobes.loadIntlSync = crcMode ? (takeNon && mark13) : takeSync;
    strobes.loadIntlNon  = crcMode ? (takeNon && mark15) : takeNon;
    strobes.alarmClear   = !inAlign;
  end

  // R11: any load happens inside a strobe run that began earlier
  p_load_in_burst_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadUser || strobes.loadIntlSync || strobes.loadIntlNon)
      |-> (tsZeroStrobe && $past(tsZeroStrobe)));

  // R7: in CRC-4 mode a sync word never loads an international bit
  p_crc_sync_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (crcMode && syncFrame) |-> !(strobes.loadIntlSync || strobes.loadIntlNon));
endmodule

// File: rtl/ts0_datapath.sv
module ts0_datapath
  import ts0_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int USER_LSB  = 2,
  parameter int PERSIST   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          serialIn,
  input  ts0Strobes_t                   strobes,
  output logic [WORD_BITS-USER_LSB-1:0] userBits,
  output logic                          intlSync,
  output logic                          intlNonSync,
  output logic                          remoteAlarm
);
  localparam int USER_W = WORD_BITS - USER_LSB;
  localparam int CNT_W  = $clog2(PERSIST + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PERSIST);

  logic [WORD_BITS-1:0] shiftReg;
  logic [WORD_BITS-1:0] word;
  logic [CNT_W-1:0]     persistCnt;
  logic                 alarmBit;

  // First received bit ends up in word[0]
  assign word     = {serialIn, shiftReg[WORD_BITS-1:1]};
  assign alarmBit = word[USER_LSB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      userBits    <= '0;
      intlSync    <= 1'b0;
      intlNonSync <= 1'b0;
    end else begin
      if (strobes.loadUser)     userBits    <= word[WORD_BITS-1:USER_LSB];
      if (strobes.loadIntlSync) intlSync    <= word[0];
      if (strobes.loadIntlNon)  intlNonSync <= word[0];
    end
  end

  // Remote alarm persistence filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      persistCnt  <= '0;
      remoteAlarm <= 1'b0;
    end else if (strobes.alarmClear) begin
      persistCnt  <= '0;
      remoteAlarm <= 1'b0;
    end else if (strobes.loadUser) begin
      if (alarmBit) begin
        if (persistCnt < CNT_MAX) persistCnt <= persistCnt + 1'b1;
        remoteAlarm <= (persistCnt + 1'b1 >= CNT_MAX);
      end else begin
        persistCnt  <= '0;
        remoteAlarm <= 1'b0;
      end
    end
  end

  p_user_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadUser |=> $stable(userBits));

  p_sync_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadIntlSync |=> $stable(intlSync));

  p_alarm_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.alarmClear |=> !remoteAlarm);

  // R8: a rising alarm always comes with a captured bit 3 of 1
  p_alarm_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(remoteAlarm) |-> userBits[0]);
endmodule

// File: rtl/ts0_extract.sv
module ts0_extract
  import ts0_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int USER_LSB  = 2,
  parameter int PERSIST   = 2,
  localparam int USER_W   = WORD_BITS - USER_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic              tsZeroStrobe,
  input  logic              syncFrame,
  input  logic              inAlign,
  input  logic              crcMode,
  input  logic              mark13,
  input  logic              mark15,
  output logic [USER_W-1:0] userBits,
  output logic              intlSync,
  output logic              intlNonSync,
  output logic              remoteAlarm
);
  ts0Strobes_t strobes;

  ts0_ctrl #(.WORD_BITS(WORD_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .tsZeroStrobe(tsZeroStrobe), .syncFrame(syncFrame),
    .inAlign(inAlign), .crcMode(crcMode), .mark13(mark13), .mark15(mark15),
    .strobes(strobes)
  );

  ts0_datapath #(.WORD_BITS(WORD_BITS), .USER_LSB(USER_LSB), .PERSIST(PERSIST)) i_dp (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .strobes(strobes),
    .userBits(userBits), .intlSync(intlSync), .intlNonSync(intlNonSync),
    .remoteAlarm(remoteAlarm)
  );
endmodule

// File: tb/test_ts0_extract.sv
module test_ts0_extract;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialIn = 1'b0, tsZeroStrobe = 1'b0, syncFrame = 1'b0, inAlign = 1'b0;
  logic crcMode = 1'b0, mark13 = 1'b0, mark15 = 1'b0;
  logic [5:0] userBits;
  logic intlSync, intlNonSync, remoteAlarm;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ts0_extract i_ts0_extract (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .tsZeroStrobe(tsZeroStrobe),
    .syncFrame(syncFrame), .inAlign(inAlign), .crcMode(crcMode),
    .mark13(mark13), .mark15(mark15), .userBits(userBits), .intlSync(intlSync),
    .intlNonSync(intlNonSync), .remoteAlarm(remoteAlarm)
  );

  typedef struct packed {
    logic [7:0] w;     // w[0] = bit 1 on the line
    logic       sync;
    logic       align;
    logic       crc;
    logic       m13;
    logic       m15;
    logic [5:0] eu;
    logic       es;
    logic       en;
    logic       ea;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'b1010_1101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b101011, 1'b0, 1'b1, 1'b0}, // R2 R6
    '{8'b1101_1001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b101011, 1'b1, 1'b1, 1'b0}, // R5 R3
    '{8'b0000_0110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000001, 1'b1, 1'b0, 1'b1}, // R8
    '{8'b1111_1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000001, 1'b1, 1'b0, 1'b0}, // R4 R10
    '{8'b0000_0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000001, 1'b1, 1'b0, 1'b0}, // R10
    '{8'b1111_0111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b111101, 1'b1, 1'b1, 1'b1}, // R8
    '{8'b0011_0010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b001100, 1'b1, 1'b0, 1'b0}, // R9
    '{8'b1001_1010, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'b001100, 1'b1, 1'b0, 1'b0}, // R7
    '{8'b0100_0101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'b010001, 1'b1, 1'b0, 1'b0}, // R7
    '{8'b0000_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0}, // R7
    '{8'b0000_0101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'b000001, 1'b0, 1'b1, 1'b0}, // R7
    '{8'b0000_0100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'b000001, 1'b0, 1'b0, 1'b1}, // R7 R8
    '{8'b0000_0001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 6'b000001, 1'b0, 1'b0, 1'b1}  // R7
  };
  localparam string VTAG [NV] = '{"R2/R6", "R5/R3", "R8", "R4/R10", "R10", "R8",
                                  "R9", "R7", "R7", "R7", "R7", "R7/R8", "R7"};

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got user=%b s=%b n=%b alarm=%b expected user=%b s=%b n=%b alarm=%b",
               tag, act[8:3], act[2], act[1], act[0], exp[8:3], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [8:0] outs();
    return {userBits, intlSync, intlNonSync, remoteAlarm};
  endfunction

  // Sends nBits of w, bit 1 first; leaves the strobe low at the following negedge
  task automatic sendWord(input logic [7:0] w, input int nBits, input logic sync,
                          input logic align, input logic crc, input logic m13,
                          input logic m15);
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk);
      tsZeroStrobe = 1'b1; serialIn = w[i]; syncFrame = sync; inAlign = align;
      crcMode = crc; mark13 = m13; mark15 = m15;
    end
    @(negedge clk);
    tsZeroStrobe = 1'b0; serialIn = 1'b0; mark13 = 1'b0; mark15 = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [8:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset", outs(), 9'b0);
    rstN = 1'b1;
    inAlign = 1'b1;
    @(negedge clk);
    check("R1 after release", outs(), 9'b0);

    for (int v = 0; v < NV; v++) begin
      sendWord(VEC[v].w, 8, VEC[v].sync, VEC[v].align, VEC[v].crc, VEC[v].m13, VEC[v].m15);
      check(VTAG[v], outs(), {VEC[v].eu, VEC[v].es, VEC[v].en, VEC[v].ea});
      repeat (3) @(negedge clk);
    end

    // R11: five strobe bits, then the strobe drops, then three more
    held = outs();
    sendWord(8'b1111_1010, 5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    sendWord(8'b0000_0111, 3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R11 short burst", outs(), held);

    // R10: alignment loss outside timeslot zero clears the alarm at the next edge
    inAlign = 1'b0;
    @(negedge clk);
    check("R10 idle loss", outs(), {held[8:1], 1'b0});
    inAlign = 1'b1;

    // R1: a reset in the middle of operation returns everything to zero
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid reset", outs(), 9'b0);
    rstN = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule